// File: doc/BRIEF.md
# Convolution Address Sequencer

This block produces the memory offsets that a convolution engine walks through, one address per clock while its enable input is high. One of four walks is picked by a mode input: reading zero-padded stored samples, reading a circular buffer of streaming samples, reading the reversed impulse response, and writing results back. Lengths N (data) and M (impulse) and a base address come in as configuration. The emitted address is the base plus an internal offset.

The offset register is updated every enabled cycle by one shared add/subtract unit. A correction term and an add-or-subtract select are chosen from two loop counters and their terminal comparisons. The same counters and one adder therefore yield a modulo walk, a divide walk, a sliding window and a wrapped sliding window, with no multiplier or divider. After the last address of a walk, a done pulse follows and the walk starts again from offset zero. Configuration is held stable from reset until done, with N and M at least 1 and N+M−1 below 2^CW.

Top module: `conv_addr_gen`

## Requirements
- R1: In a clock where `en` is high the internal state advances by exactly one address; where `en` is low the state and `addr` hold. `valid` equals `en`.
- R2: `addr` = `base` + offset. A synchronous active-high `rst` sets the offset and both loop counters to zero and clears `done`, so after reset `addr` equals `base`.
- R3: Mode encoding on `mode`: 0 stored-data fetch, 1 streaming-data fetch, 2 coefficient fetch, 3 result write.
- R4: Coefficient mode: with inner index j from 0 to M−1 and outer index k from 0 to N+M−2, the offset is j. It climbs by one and drops back to zero after M−1.
- R5: Result mode: the offset is k. It is held for M consecutive addresses and then rises by one, for k from 0 to N+M−2.
- R6: Stored-data mode: the data array carries M−1 zero pads at both ends. The offset is k+j, a window of M addresses that slides by one per output, for k from 0 to N+M−2.
- R7: Streaming mode: the inner counter c1 runs 0..N−1 and the outer counter c2 advances when c1 wraps, running 0..N−1. The offset is c1+c2 when that sum is below N and c1+c2−N otherwise. One walk is N×N addresses.
- R8: `done` is high for exactly the one cycle after the clock that issued the last address of a walk (N+M−1 times M addresses in modes 0, 2 and 3; N×N in mode 1). In that cycle `addr` is back at `base`.
- R9: Degenerate lengths M=1 and N=1 produce the walks above: every address is a walk end where the counts make it so.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| en | input | 1 | Address-generate enable |
| mode | input | 2 | Walk select (see R3) |
| len_n | input | CW | Data length N |
| len_m | input | CW | Impulse length M |
| base | input | AW | Base address |
| addr | output | AW | Current address |
| valid | output | 1 | Address is being consumed this cycle |
| done | output | 1 | One-cycle pulse after the walk's last address |

## Verification
The bound checker watches on every cycle that `addr` holds when `en` is low, that `done` only follows an enabled clock and lands on `base`, and the local shape of each walk. That shape covers the coefficient offset staying below M and climbing by one, the result offset never moving by more than one, and the streaming offset staying below N. The exact order of addresses, the counts at which loops wrap and the cycle of the done pulse depend on whole walks. Only the bench's scenarios show these, comparing every address against index formulas for randomly gated enables and for the M=1 and N=1 corners.

// File: rtl/cag_pkg.sv
package cag_pkg;

    typedef enum logic [1:0] {
        CAG_STORED = 2'd0,
        CAG_STREAM = 2'd1,
        CAG_COEF   = 2'd2,
        CAG_RESULT = 2'd3
    } cag_mode_e;

    typedef struct packed {
        logic inner_end;
        logic outer_end;
        logic walk_end;
    } cag_loop_t;

endpackage

// File: rtl/cag_loop_ctrl.sv
module cag_loop_ctrl
    import cag_pkg::*;
#(
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  cag_mode_e     mode,
    input  logic [CW-1:0] len_n,
    input  logic [CW-1:0] len_m,
    output logic [CW-1:0] inner_nxt,
    output logic [CW-1:0] outer_nxt,
    output cag_loop_t     flags
);
    localparam int EW = CW + 1;

    logic [CW-1:0] inner_q, outer_q;
    logic [CW-1:0] inner_lim;
    logic [EW-1:0] outer_lim;

    always_comb begin
        if (mode == CAG_STREAM) begin
            inner_lim = len_n - CW'(1);
            outer_lim = {1'b0, len_n} - EW'(1);
        end else begin
            inner_lim = len_m - CW'(1);
            outer_lim = {1'b0, len_n} + {1'b0, len_m} - EW'(2);
        end
    end

    always_comb begin
        flags.inner_end = (inner_q == inner_lim);
        flags.outer_end = ({1'b0, outer_q} == outer_lim);
        flags.walk_end  = flags.inner_end & flags.outer_end;
    end

    always_comb begin
        if (flags.walk_end) begin
            inner_nxt = '0;
            outer_nxt = '0;
        end else if (flags.inner_end) begin
            inner_nxt = '0;
            outer_nxt = outer_q + CW'(1);
        end else begin
            inner_nxt = inner_q + CW'(1);
            outer_nxt = outer_q;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            inner_q <= '0;
            outer_q <= '0;
        end else if (en) begin
            inner_q <= inner_nxt;
            outer_q <= outer_nxt;
        end
    end

endmodule

// File: rtl/cag_corr_sel.sv
module cag_corr_sel
    import cag_pkg::*;
#(
    parameter int CW = 16
) (
    input  cag_mode_e     mode,
    input  logic [CW-1:0] len_n,
    input  logic [CW-1:0] len_m,
    input  logic [CW-1:0] off_q,
    input  logic [CW-1:0] inner_nxt,
    input  logic [CW-1:0] outer_nxt,
    input  cag_loop_t     flags,
    output logic [CW:0]   opnd,
    output logic [CW:0]   corr,
    output logic          sub
);
    localparam int EW = CW + 1;

    logic [EW-1:0] win_sum;
    logic [EW-1:0] off_ext;

    assign win_sum = {1'b0, inner_nxt} + {1'b0, outer_nxt};
    assign off_ext = {1'b0, off_q};

    always_comb begin
        opnd = off_ext;
        corr = EW'(1);
        sub  = 1'b0;
        if (mode == CAG_STREAM) begin
            opnd = win_sum;
            if (win_sum >= {1'b0, len_n}) begin
                corr = {1'b0, len_n};
                sub  = 1'b1;
            end else begin
                corr = '0;
            end
        end else if (flags.walk_end) begin
            corr = off_ext;
            sub  = 1'b1;
        end else begin
            unique case (mode)
                CAG_COEF: begin
                    if (flags.inner_end) begin
                        corr = {1'b0, len_m} - EW'(1);
                        sub  = 1'b1;
                    end
                end
                CAG_RESULT: begin
                    corr = flags.inner_end ? EW'(1) : '0;
                end
                default: begin
                    if (flags.inner_end && len_m >= CW'(2)) begin
                        corr = {1'b0, len_m} - EW'(2);
                        sub  = 1'b1;
                    end
                end
            endcase
        end
    end

endmodule

// File: rtl/cag_addsub.sv
module cag_addsub #(
    parameter int W = 17
) (
    input  logic [W-1:0] a,
    input  logic [W-1:0] b,
    input  logic         sub,
    output logic [W-1:0] y
);
    assign y = sub ? (a - b) : (a + b);
endmodule

// File: rtl/conv_addr_gen.sv
module conv_addr_gen
    import cag_pkg::*;
#(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          en,
    input  logic [1:0]    mode,
    input  logic [CW-1:0] len_n,
    input  logic [CW-1:0] len_m,
    input  logic [AW-1:0] base,
    output logic [AW-1:0] addr,
    output logic          valid,
    output logic          done
);
    localparam int EW = CW + 1;

    cag_mode_e     mode_e;
    cag_loop_t     flags;
    logic [CW-1:0] inner_nxt, outer_nxt;
    logic [CW-1:0] off_q;
    logic [EW-1:0] opnd, corr, sum;
    logic          sub;
    logic          done_q;

    assign mode_e = cag_mode_e'(mode);

    cag_loop_ctrl #(.CW(CW)) u_loop (
        .clk       (clk),
        .rst       (rst),
        .en        (en),
        .mode      (mode_e),
        .len_n     (len_n),
        .len_m     (len_m),
        .inner_nxt (inner_nxt),
        .outer_nxt (outer_nxt),
        .flags     (flags)
    );

    cag_corr_sel #(.CW(CW)) u_corr (
        .mode      (mode_e),
        .len_n     (len_n),
        .len_m     (len_m),
        .off_q     (off_q),
        .inner_nxt (inner_nxt),
        .outer_nxt (outer_nxt),
        .flags     (flags),
        .opnd      (opnd),
        .corr      (corr),
        .sub       (sub)
    );

    cag_addsub #(.W(EW)) u_add (
        .a   (opnd),
        .b   (corr),
        .sub (sub),
        .y   (sum)
    );

    always_ff @(posedge clk) begin
        if (rst) begin
            off_q  <= '0;
            done_q <= 1'b0;
        end else begin
            done_q <= en & flags.walk_end;
            if (en) begin
                off_q <= sum[CW-1:0];
            end
        end
    end

    assign addr  = base + AW'(off_q);
    assign valid = en;
    assign done  = done_q;

endmodule

// File: rtl/cag_checker.sv
module cag_checker #(
    parameter int AW = 16,
    parameter int CW = 16
) (
    input logic          clk,
    input logic          rst,
    input logic          en,
    input logic [1:0]    mode,
    input logic [CW-1:0] len_n,
    input logic [CW-1:0] len_m,
    input logic [AW-1:0] base,
    input logic [AW-1:0] addr,
    input logic          done
);
    logic [AW-1:0] rel;
    assign rel = addr - base;

    a_r1_hold: assert property (@(posedge clk) disable iff (rst)
        !en |=> $stable(addr));

    a_r8_done_after_en: assert property (@(posedge clk) disable iff (rst)
        done |-> $past(en));

    a_r8_done_restart: assert property (@(posedge clk) disable iff (rst)
        done |-> (addr == base));

    a_r4_coef_range: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2) |-> (rel < AW'(len_m)));

    a_r4_coef_step: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd2 && $past(en) && rel != '0) |-> (addr == $past(addr) + AW'(1)));

    a_r5_result_step: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd3 && $past(en))
            |-> (addr == $past(addr) || addr == $past(addr) + AW'(1) || addr == base));

    a_r7_stream_range: assert property (@(posedge clk) disable iff (rst)
        (mode == 2'd1) |-> (rel < AW'(len_n)));

endmodule

bind conv_addr_gen cag_checker #(.AW(AW), .CW(CW)) u_chk (.*);

// File: tb/sim_conv_addr_gen.sv
module sim_conv_addr_gen;
    localparam int AW = 16;
    localparam int CW = 16;

    logic          clk = 1'b0;
    logic          rst = 1'b1;
    logic          en = 1'b0;
    logic [1:0]    mode = 2'd0;
    logic [CW-1:0] len_n = CW'(1);
    logic [CW-1:0] len_m = CW'(1);
    logic [AW-1:0] base = '0;
    logic [AW-1:0] addr;
    logic          valid;
    logic          done;

    int n_chk = 0;
    int n_fail = 0;
    bit finished = 0;

    always #2 clk = ~clk;

    conv_addr_gen #(.AW(AW), .CW(CW)) u0 (
        .clk(clk), .rst(rst), .en(en), .mode(mode), .len_n(len_n),
        .len_m(len_m), .base(base), .addr(addr), .valid(valid), .done(done)
    );

    function automatic int exp_off(int md, int n, int j, int k);
        case (md)
            0: return k + j;
            1: return (j + k) % n;
            2: return j;
            default: return k;
        endcase
    endfunction

    function automatic string mode_req(int md);
        case (md)
            0: return "R6";
            1: return "R7";
            2: return "R4";
            default: return "R5";
        endcase
    endfunction

    task automatic check(bit ok, string req, int act, int exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic run_cfg(int md, int n, int m, int b, int en_pct, string tag);
        int j = 0, k = 0, li, lo, pend_done = 0, walks = 0, prev_addr;
        bit prev_en = 0;
        li = (md == 1) ? n : m;
        lo = (md == 1) ? n : n + m - 1;
        @(negedge clk);
        rst = 1'b1; en = 1'b0;
        mode = md[1:0]; len_n = CW'(n); len_m = CW'(m); base = AW'(b);
        @(negedge clk);
        rst = 1'b0;
        #1;
        check(addr == AW'(b) && done == 1'b0, "R2 reset", int'(addr), b);
        prev_addr = int'(addr);
        @(negedge clk);
        while (walks < 2) begin
            en = (($urandom % 100) < en_pct);
            #1;
            check(addr == AW'(b + exp_off(md, n, j, k)),
                  {mode_req(md), (m == 1 || n == 1) ? " R9 " : " ", tag},
                  int'(addr), int'(AW'(b + exp_off(md, n, j, k))));
            if (!prev_en)
                check(int'(addr) == prev_addr, "R1 hold", int'(addr), prev_addr);
            check(valid == en, "R1 valid", int'(valid), int'(en));
            check(done == pend_done[0], "R8 done", int'(done), pend_done);
            if (done)
                check(addr == AW'(b), "R8 restart", int'(addr), b);
            prev_addr = int'(addr);
            prev_en = en;
            if (en) begin
                pend_done = (j == li - 1 && k == lo - 1) ? 1 : 0;
                if (pend_done == 1) begin
                    j = 0; k = 0; walks++;
                end else if (j == li - 1) begin
                    j = 0; k++;
                end else begin
                    j++;
                end
            end else begin
                pend_done = 0;
            end
            @(negedge clk);
        end
        en = 1'b0;
        #1;
        check(done == pend_done[0], "R8 final done", int'(done), pend_done);
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=completion");
        finish_run();
    end

    initial begin
        void'($urandom(32'd1234));
        repeat (3) @(negedge clk);
        // directed walks, one per mode (R3 encodings)
        run_cfg(2, 3, 4, 100, 100, "coef");
        run_cfg(3, 3, 4, 200, 100, "result");
        run_cfg(0, 4, 3, 300, 100, "stored");
        run_cfg(1, 5, 2, 400, 100, "stream");
        // degenerate lengths, R9
        run_cfg(0, 4, 1, 10, 80, "m1");
        run_cfg(2, 1, 1, 20, 80, "n1m1");
        run_cfg(1, 1, 3, 30, 80, "n1");
        run_cfg(3, 1, 3, 40, 80, "n1res");
        // base wrap near top of the address space, R2
        run_cfg(0, 3, 3, 65533, 90, "wrap");
        // random configurations with gated enable
        for (int i = 0; i < 16; i++) begin
            run_cfg(int'($urandom % 4), 1 + int'($urandom % 6), 1 + int'($urandom % 5),
                    int'($urandom % 65536), 40 + int'($urandom % 60), "rand");
        end
        finish_run();
    end

endmodule